// File: doc/BRIEF.md
# Dual-Edge Pixel Bus Demultiplexer

This block sits at the input of a video encoder. It takes an 8-bit pixel bus clocked at twice the pixel rate, where each clock cycle carries two independent 4:2:2 component streams. One stream is sampled on the rising clock edge and feeds the encoded path. The other is sampled on the falling edge and feeds the baseband path. The falling-edge sample is retimed into the rising-edge domain, so both channels give one sample per clock in the same cycle.

A one-bit line-start mark travels with the bus and is sampled on the same edges as the data. A mark on a sample means that this sample is the first Cb of a new active line for that stream. Each channel then labels the samples that follow with a component tag and counts them. Once a full line (twice the active pixel count, 1440 by default) has been delivered, the channel stops. If the next sample then arrives with no new mark, the channel raises a sticky overrun flag and holds its last output.

Top module: `vdm_dual_demux`

## Requirements
- R1: The sample present at rising edge n goes to the encoded channel, and the sample present at the falling edge that follows goes to the baseband channel. Both are visible on the outputs after rising edge n+2, in the same cycle.
- R2: A sample that carries the line-start mark is delivered with valid=1, sol=1 and tag 0 (Cb). Every other output cycle has sol=0.
- R3: Within a line the tags follow the order 0 (Cb), 1 (Y0), 2 (Cr), 3 (Y1), then repeat from 0.
- R4: A mark in the middle of a line restarts the tag order at Cb and restarts the sample count.
- R5: At most LINE_SAMPLES = 2*ACTIVE_PIXELS valid samples follow one mark. The next sample without a mark gives valid=0 and overrun=1. Valid and overrun are never both high.
- R6: Whenever valid is low, the data and tag outputs keep the values of the last valid sample, or zero if there has been none since reset.
- R7: Overrun stays high until the next mark on that stream. It is cleared in the same output cycle that delivers the marked sample.
- R8: After reset and before the first mark, bus samples are ignored: valid=0 and overrun=0.
- R9: While rst_n is low at a rising edge, all outputs of both channels go to zero.
- R10: The two channels are independent. A mark on one stream does not change the tags, counts or flags of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | DATA_W | Double-rate multiplexed pixel bus |
| bus_mark | input | 1 | Line-start mark, sampled on the same edges as bus_data |
| enc_data | output | DATA_W | Encoded-path sample (rising-edge stream) |
| enc_tag | output | 2 | Encoded-path component tag: 0 Cb, 1 Y0, 2 Cr, 3 Y1 |
| enc_valid | output | 1 | Encoded-path sample is valid |
| enc_sol | output | 1 | Encoded-path first sample of a line |
| enc_ovr | output | 1 | Encoded-path sticky overrun |
| bb_data | output | DATA_W | Baseband-path sample (falling-edge stream) |
| bb_tag | output | 2 | Baseband-path component tag |
| bb_valid | output | 1 | Baseband-path sample is valid |
| bb_sol | output | 1 | Baseband-path first sample of a line |
| bb_ovr | output | 1 | Baseband-path sticky overrun |

## Verification
The bench drives different byte patterns on the two edges of each clock cycle. A design that swapped the edges, or failed to delay the rising sample to match the retimed falling one, would show the wrong byte or a one-cycle skew on one channel. It places marks in the middle of a line and on only one stream. A tag counter that failed to restart, or that was shared between channels, would give the wrong tag on the following samples. It also runs a full 1440-sample line followed by extra samples. A length counter that was off by one would deliver 1439 or 1441 samples, and an overrun that was not held, or not cleared by the next mark, would show on the flag and on the held data.

// File: rtl/vdm_pkg.sv
// Shared types for the dual-edge pixel bus demultiplexer.
package vdm_pkg;
    // Component position within a 4:2:2 pixel pair
    typedef enum logic [1:0] {
        CMP_CB = 2'd0,
        CMP_Y0 = 2'd1,
        CMP_CR = 2'd2,
        CMP_Y1 = 2'd3
    } comp_e;
endpackage

// File: rtl/vdm_edge_capture.sv
// Captures the bus on both clock edges and retimes the two lanes into the
// rising-edge domain so that lane 0 (rising) and lane 1 (falling) of one
// bus cycle come out together.
// Assumes: bus_data/bus_mark are stable around both clock edges.
module vdm_edge_capture #(
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DATA_W-1:0]           bus_data,
    input  logic                        bus_mark,
    output logic [1:0][DATA_W-1:0]      lane_data,
    output logic [1:0]                  lane_mark
);
    logic [DATA_W:0] rise_q, rise_d, fall_q, fall_rt;

    // Sample the rising-edge stream
    always_ff @(posedge clk) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= {bus_mark, bus_data};
    end

    // Sample the falling-edge stream
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= {bus_mark, bus_data};
    end

    // Delay the rising lane one cycle and retime the falling lane, aligning both
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_d  <= '0;
            fall_rt <= '0;
        end else begin
            rise_d  <= rise_q;
            fall_rt <= fall_q;
        end
    end

    // Split the aligned words into data and mark lanes
    always_comb begin
        lane_data[0] = rise_d[DATA_W-1:0];
        lane_mark[0] = rise_d[DATA_W];
        lane_data[1] = fall_rt[DATA_W-1:0];
        lane_mark[1] = fall_rt[DATA_W];
    end
endmodule

// File: rtl/vdm_stream_parser.sv
// Tracks one component stream: the line-start mark restarts the tag order at
// Cb and the sample count. Samples are delivered until LINE_SAMPLES have gone
// out. A further sample without a mark sets a sticky overrun, and the outputs
// hold their last value.
// Assumes: one input sample per clock, already in the rising-edge domain.
module vdm_stream_parser
    import vdm_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int LINE_SAMPLES = 1440
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_mark,
    output logic [DATA_W-1:0] out_data,
    output comp_e             out_tag,
    output logic              out_valid,
    output logic              out_sol,
    output logic              out_ovr
);
    localparam int CNT_W = $clog2(LINE_SAMPLES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LINE_SAMPLES);

    logic             running;
    logic [CNT_W-1:0] count;
    comp_e            phase;
    logic             line_full;

    assign line_full = (count == CNT_FULL);

    // Line state, tag sequencing and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            count     <= '0;
            phase     <= CMP_CB;
            out_data  <= '0;
            out_tag   <= CMP_CB;
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_ovr   <= 1'b0;
        end else if (in_mark) begin
            running   <= 1'b1;
            count     <= CNT_W'(1);
            phase     <= CMP_Y0;
            out_data  <= in_data;
            out_tag   <= CMP_CB;
            out_valid <= 1'b1;
            out_sol   <= 1'b1;
            out_ovr   <= 1'b0;
        end else if (running && !line_full) begin
            count     <= count + CNT_W'(1);
            phase     <= comp_e'(phase + 2'd1);
            out_data  <= in_data;
            out_tag   <= phase;
            out_valid <= 1'b1;
            out_sol   <= 1'b0;
        end else if (running) begin
            running   <= 1'b0;
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_ovr   <= 1'b1;
        end else begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
        end
    end
endmodule

// File: rtl/vdm_dual_demux.sv
// Top level: splits the double-rate bus into an encoded channel (rising edge)
// and a baseband channel (falling edge), each with tags, line start and
// overrun, delivered in lockstep on the rising edge.
// Assumes: clk is the double-rate bus clock and rst_n is synchronous.
module vdm_dual_demux
    import vdm_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int ACTIVE_PIXELS = 720
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_mark,
    output logic [DATA_W-1:0] enc_data,
    output logic [1:0]        enc_tag,
    output logic              enc_valid,
    output logic              enc_sol,
    output logic              enc_ovr,
    output logic [DATA_W-1:0] bb_data,
    output logic [1:0]        bb_tag,
    output logic              bb_valid,
    output logic              bb_sol,
    output logic              bb_ovr
);
    localparam int LINE_SAMPLES = 2 * ACTIVE_PIXELS;
    localparam int NUM_LANES    = 2;

    logic [NUM_LANES-1:0][DATA_W-1:0] lane_data;
    logic [NUM_LANES-1:0]             lane_mark;
    logic [NUM_LANES-1:0][DATA_W-1:0] ch_data;
    comp_e                            ch_tag [NUM_LANES];
    logic [NUM_LANES-1:0]             ch_valid, ch_sol, ch_ovr;

    vdm_edge_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_data  (bus_data),
        .bus_mark  (bus_mark),
        .lane_data (lane_data),
        .lane_mark (lane_mark)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        vdm_stream_parser #(
            .DATA_W       (DATA_W),
            .LINE_SAMPLES (LINE_SAMPLES)
        ) u_parse (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_data   (lane_data[g]),
            .in_mark   (lane_mark[g]),
            .out_data  (ch_data[g]),
            .out_tag   (ch_tag[g]),
            .out_valid (ch_valid[g]),
            .out_sol   (ch_sol[g]),
            .out_ovr   (ch_ovr[g])
        );
    end

    // Map lane 0 to the encoded path and lane 1 to the baseband path
    always_comb begin
        enc_data  = ch_data[0];
        enc_tag   = ch_tag[0];
        enc_valid = ch_valid[0];
        enc_sol   = ch_sol[0];
        enc_ovr   = ch_ovr[0];
        bb_data   = ch_data[1];
        bb_tag    = ch_tag[1];
        bb_valid  = ch_valid[1];
        bb_sol    = ch_sol[1];
        bb_ovr    = ch_ovr[1];
    end
endmodule

// Protocol checker for both output channels of vdm_dual_demux.
module vdm_dual_demux_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] enc_data,
    input logic [1:0]        enc_tag,
    input logic              enc_valid,
    input logic              enc_sol,
    input logic              enc_ovr,
    input logic [DATA_W-1:0] bb_data,
    input logic [1:0]        bb_tag,
    input logic              bb_valid,
    input logic              bb_sol,
    input logic              bb_ovr
);
    // R5
    enc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(enc_valid && enc_ovr));
    // R5
    bb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bb_valid && bb_ovr));
    // R2
    enc_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_sol |-> (enc_valid && enc_tag == 2'd0));
    // R2
    bb_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bb_sol |-> (bb_valid && bb_tag == 2'd0));
    // R3
    enc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid && !enc_sol && $past(enc_valid)) |-> enc_tag == $past(enc_tag) + 2'd1);
    // R3
    bb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_valid && !bb_sol && $past(bb_valid)) |-> bb_tag == $past(bb_tag) + 2'd1);
    // R6
    enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid |-> ($stable(enc_data) && $stable(enc_tag)));
    // R6
    bb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bb_valid |-> ($stable(bb_data) && $stable(bb_tag)));
    // R7
    enc_ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enc_ovr) |-> $past(enc_valid));
    // R7
    bb_ovr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bb_ovr) |-> bb_sol);
endmodule

bind vdm_dual_demux vdm_dual_demux_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enc_data  (enc_data),
    .enc_tag   (enc_tag),
    .enc_valid (enc_valid),
    .enc_sol   (enc_sol),
    .enc_ovr   (enc_ovr),
    .bb_data   (bb_data),
    .bb_tag    (bb_tag),
    .bb_valid  (bb_valid),
    .bb_sol    (bb_sol),
    .bb_ovr    (bb_ovr)
);

// File: tb/tb_vdm_dual_demux.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver models each stream from the requirements and
// queues the expected output record; the monitor compares it three negedges later.
module tb_vdm_dual_demux;
    localparam int DATA_W = 8;
    localparam int LINE   = 1440;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [1:0]        tag;
        logic              sol;
        logic              ovr;
    } rec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DATA_W-1:0] bus_data = '0;
    logic bus_mark = 1'b0;
    logic [DATA_W-1:0] enc_data, bb_data;
    logic [1:0] enc_tag, bb_tag;
    logic enc_valid, enc_sol, enc_ovr, bb_valid, bb_sol, bb_ovr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rec_t q_enc[$];
    rec_t q_bb[$];

    // Reference model state per stream (0 encoded, 1 baseband)
    bit   m_run [2];
    int   m_cnt [2];
    int   m_ph  [2];
    bit   m_ovr [2];
    logic [DATA_W-1:0] m_last [2];
    logic [1:0]        m_ltag [2];

    always #2.5 clk = ~clk;

    vdm_dual_demux dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_mark(bus_mark),
        .enc_data(enc_data), .enc_tag(enc_tag), .enc_valid(enc_valid),
        .enc_sol(enc_sol), .enc_ovr(enc_ovr),
        .bb_data(bb_data), .bb_tag(bb_tag), .bb_valid(bb_valid),
        .bb_sol(bb_sol), .bb_ovr(bb_ovr)
    );

    function automatic rec_t model(int s, logic [DATA_W-1:0] b, bit m);
        rec_t r;
        if (m) begin
            m_run[s] = 1; m_cnt[s] = 1; m_ph[s] = 1; m_ovr[s] = 0;
            m_last[s] = b; m_ltag[s] = 2'd0;
            r = '{1'b1, b, 2'd0, 1'b1, 1'b0};
        end else if (m_run[s] && m_cnt[s] < LINE) begin
            m_last[s] = b; m_ltag[s] = 2'(m_ph[s]);
            r = '{1'b1, b, 2'(m_ph[s]), 1'b0, 1'b0};
            m_cnt[s]++; m_ph[s] = (m_ph[s] + 1) % 4;
        end else begin
            if (m_run[s]) begin m_run[s] = 0; m_ovr[s] = 1; end
            r = '{1'b0, m_last[s], m_ltag[s], 1'b0, m_ovr[s]};
        end
        return r;
    endfunction

    // One bus cycle: rising-edge sample (ra, rm) then falling-edge sample (fa, fm)
    task automatic step(logic [DATA_W-1:0] ra, bit rm, logic [DATA_W-1:0] fa, bit fm);
        @(negedge clk); #1;
        bus_data = ra; bus_mark = rm;
        q_enc.push_back(model(0, ra, rm));
        q_bb.push_back(model(1, fa, fm));
        @(posedge clk); #1;
        bus_data = fa; bus_mark = fm;
    endtask

    task automatic cmp(string ch, rec_t act, rec_t exp);
        string req;
        checks++;
        if (act !== exp) begin
            errors++;
            if (act.valid !== exp.valid || act.ovr !== exp.ovr) req = "R5";
            else if (act.sol !== exp.sol) req = "R2";
            else if (act.tag !== exp.tag) req = "R3";
            else if (!exp.valid) req = "R6";
            else req = "R1";
            $display("FAIL %s %s actual=%h expected=%h (valid,data,tag,sol,ovr)", req, ch, act, exp);
        end
    endtask

    // Monitor: compare outputs against records pushed three cycles earlier
    always @(negedge clk) begin
        if (q_enc.size() >= 3) cmp("enc", {enc_valid, enc_data, enc_tag, enc_sol, enc_ovr}, q_enc.pop_front());
        if (q_bb.size() >= 3)  cmp("bb",  {bb_valid, bb_data, bb_tag, bb_sol, bb_ovr}, q_bb.pop_front());
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_run[s] = 0; m_cnt[s] = 0; m_ph[s] = 0; m_ovr[s] = 0;
            m_last[s] = '0; m_ltag[s] = '0;
        end
        bus_data = 8'hA5; bus_mark = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: every output is zero under reset, even with a mark on the bus
        checks++;
        if ({enc_data, enc_tag, enc_valid, enc_sol, enc_ovr, bb_data, bb_tag, bb_valid, bb_sol, bb_ovr} !== '0) begin
            errors++;
            $display("FAIL R9 reset outputs actual=%h expected=0",
                {enc_data, enc_tag, enc_valid, enc_sol, enc_ovr, bb_data, bb_tag, bb_valid, bb_sol, bb_ovr});
        end
        bus_mark = 1'b0;
        #1 rst_n = 1'b1;
        // R8: samples before any mark are ignored
        for (int i = 0; i < 6; i++) step(8'h30 + 8'(i), 0, 8'hE0 - 8'(i), 0);
        // R1 R2 R3: both streams start a line, with distinct data on each edge
        for (int i = 0; i < 10; i++) step(8'h10 + 8'(i), i == 0, 8'hC0 ^ 8'(i), i == 0);
        // R4: mid-line mark restarts both streams at Cb
        for (int i = 0; i < 9; i++) step(8'h50 + 8'(3*i), i == 1, 8'h90 + 8'(i), i == 1);
        // R10: mark on the encoded stream only; baseband continues its order
        for (int i = 0; i < 7; i++) step(8'h70 + 8'(i), i == 2, 8'h05 + 8'(i), 0);
        // R5 R6 R7: full line on both streams, then samples with no mark
        for (int i = 0; i < LINE + 6; i++) step(8'(i * 7), i == 0, 8'(255 - i), i == 0);
        // R7: a new encoded mark clears its overrun; baseband stays in overrun
        for (int i = 0; i < 5; i++) step(8'h3C + 8'(i), i == 0, 8'h11, 0);
        for (int i = 0; i < 4; i++) step(8'h00, 0, 8'h00, 0);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule